// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two component predictors. The first is a per-address table of 2-bit saturating counters. The second is a single table of 2-bit counters, indexed by a global register that holds the most recent resolved outcomes. A third table of 2-bit chooser counters, indexed by address, decides which component to follow when the two give different answers. When both components give the same answer, that answer is the prediction.

A fetch stage drives a program counter onto the lookup port and receives a taken/not-taken guess in the same cycle. An execute stage reports each resolved branch on the update port with its address and actual direction. That report trains the counters and shifts the history register on the next clock edge. The block does not predict targets, does not repair history speculatively and does not control flushes.

Top module: `tourn_predictor`

## Requirements
- R1: After reset, every counter in the three tables holds 01 and the history register holds zero. Every lookup therefore predicts not taken until the first update.
- R2: On an update, the per-address counter selected by the update address moves up by one on a taken outcome and down by one on a not-taken outcome. It stays at 11 when it is already 11 and the outcome is taken, and at 00 when it is already 00 and the outcome is not taken.
- R3: A component counter predicts taken when its value is 10 or 11 (MSB 1). It predicts not taken when its value is 00 or 01.
- R4: When the two components agree, the lookup output (1 = taken) equals their common direction, whatever the chooser counter holds.
- R5: Every update shifts its outcome into bit 0 of the history register (1 = taken) and drops the oldest bit. Cycles without an update leave the register unchanged. The history-indexed table is addressed by the full register value.
- R6: When the two components disagree, a chooser counter with MSB 1 selects the history-indexed prediction and MSB 0 selects the per-address prediction.
- R7: The chooser counter at the update address changes only when the two component predictions at update time differ. It then moves up by one (saturating at 11) if the history-indexed component was right, and down by one (saturating at 00) if the per-address component was right.
- R8: The per-address and chooser tables are indexed by PC bits [ALIGN_W+BIDX_W-1:ALIGN_W]. Addresses that differ only outside that field share entries.
- R9: An update reads the counters as they stand in its own cycle and uses the history value from before its shift. Its effect is visible on the lookup output from the cycle after the update, not in the update cycle.
- R10: On an update, the history-indexed counter moves up by one on a taken outcome and down by one on a not-taken outcome, saturating at 11 and 00 like the per-address counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being fetched |
| lk_taken | output | 1 | Predicted direction for lk_pc, 1 = taken |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch, 1 = taken |

## Verification
The bench builds the block with BIDX_W = 4 and GHR_W = 3. This gives 16 per-address entries and 8 history-indexed entries. A pool of 24 branch addresses then collides in the per-address and chooser tables, and the history table is revisited constantly. Short runs of same-direction outcomes drive counters into both saturation limits, and both chooser limits are reached through long disagreement streaks. Alignment bits and high address bits are varied, which exercises the index-field aliasing. Same-cycle lookups of the updated address show that an update takes effect only after the clock edge.

// File: rtl/tourn_pkg.sv
// Shared types and counter arithmetic for the tournament predictor.
// Assumes every table entry is a 2-bit saturating counter whose MSB is the
// predicted direction.
package tourn_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_INIT = 2'b01;
    localparam ctr2_t CTR_MAX  = 2'b11;
    localparam ctr2_t CTR_MIN  = 2'b00;

    // Saturating step: up when inc is 1, down otherwise.
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic inc);
        ctr2_t r;
        if (inc) r = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
        else     r = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
        return r;
    endfunction

    // Direction encoded by a counter value.
    function automatic logic ctr_dir(input ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
// Table of 2-bit saturating counters with two combinational read ports and
// one write port that steps a single entry per cycle.
// Assumes a write and a read of the same entry in one cycle returns the old
// value. All entries reset to the weakly-not-taken value.
module tp_ctr_table
    import tourn_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output ctr2_t            rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output ctr2_t            rd_b_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_inc
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t ents_q [DEPTH];

    // Reset every entry, otherwise step the written one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ents_q[i] <= CTR_INIT;
            end
        end else if (wr_en) begin
            ents_q[wr_idx] <= ctr_step(ents_q[wr_idx], wr_inc);
        end
    end

    // Combinational reads for lookup and update sides.
    always_comb begin
        rd_a_val = ents_q[rd_a_idx];
        rd_b_val = ents_q[rd_b_idx];
    end

endmodule

// File: rtl/tp_ghist.sv
// Global outcome history shift register shared by all branches.
// Newest outcome enters at bit 0; shifts only when shift_en is high.
module tp_ghist #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist
);
    generate
        if (W == 1) begin : g_one
            // Single-bit history just records the last outcome.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= bit_in;
            end
        end else begin : g_many
            // Shift left, dropping the oldest outcome.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= {hist[W-2:0], bit_in};
            end
        end
    endgenerate

endmodule

// File: rtl/tp_chooser.sv
// Picks the final direction from two component directions and a chooser
// counter. Assumes chooser MSB 1 means trust the history-indexed component.
module tp_chooser
    import tourn_pkg::*;
(
    input  logic  bim_dir,
    input  logic  glb_dir,
    input  ctr2_t vote,
    output logic  final_dir
);
    // Agreement passes through; disagreement defers to the chooser.
    always_comb begin
        if (bim_dir == glb_dir) final_dir = bim_dir;
        else                    final_dir = ctr_dir(vote) ? glb_dir : bim_dir;
    end

endmodule

// File: rtl/tourn_predictor.sv
// Tournament branch direction predictor: per-address counters, a
// global-history-indexed counter table and a per-address chooser table.
// Assumes one resolved branch at most per cycle, and that updates arrive
// in program order. No speculative history is kept.
module tourn_predictor
    import tourn_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ALIGN_W = 2,
    parameter int BIDX_W  = 8,
    parameter int GHR_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    logic [BIDX_W-1:0] bidx_lk;
    logic [BIDX_W-1:0] bidx_u;
    logic [GHR_W-1:0]  ghr;
    ctr2_t             bim_lk, bim_u;
    ctr2_t             glb_lk, glb_u;
    ctr2_t             vote_lk, vote_u;
    logic              bp_lk, gp_lk, bp_u, gp_u;
    logic              vote_wr;
    logic              unused_pc;

    // Index field extraction for lookup and update addresses.
    always_comb begin
        bidx_lk   = lk_pc[ALIGN_W +: BIDX_W];
        bidx_u    = upd_pc[ALIGN_W +: BIDX_W];
        unused_pc = ^lk_pc ^ ^upd_pc;
    end

    tp_ctr_table #(.IDX_W(BIDX_W)) u_bim (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (bidx_lk),
        .rd_a_val (bim_lk),
        .rd_b_idx (bidx_u),
        .rd_b_val (bim_u),
        .wr_en    (upd_valid),
        .wr_idx   (bidx_u),
        .wr_inc   (upd_taken)
    );

    tp_ctr_table #(.IDX_W(GHR_W)) u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ghr),
        .rd_a_val (glb_lk),
        .rd_b_idx (ghr),
        .rd_b_val (glb_u),
        .wr_en    (upd_valid),
        .wr_idx   (ghr),
        .wr_inc   (upd_taken)
    );

    tp_ctr_table #(.IDX_W(BIDX_W)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (bidx_lk),
        .rd_a_val (vote_lk),
        .rd_b_idx (bidx_u),
        .rd_b_val (vote_u),
        .wr_en    (vote_wr),
        .wr_idx   (bidx_u),
        .wr_inc   (gp_u == upd_taken)
    );

    tp_ghist #(.W(GHR_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (ghr)
    );

    // Component directions and chooser training enable.
    always_comb begin
        bp_lk   = ctr_dir(bim_lk);
        gp_lk   = ctr_dir(glb_lk);
        bp_u    = ctr_dir(bim_u);
        gp_u    = ctr_dir(glb_u);
        vote_wr = upd_valid && (bp_u != gp_u);
    end

    tp_chooser u_pick (
        .bim_dir   (bp_lk),
        .glb_dir   (gp_lk),
        .vote      (vote_lk),
        .final_dir (lk_taken)
    );

endmodule

// File: rtl/tourn_predictor_chk.sv
// Property checker for tourn_predictor, attached by bind below.
module tourn_predictor_chk #(
    parameter int BIDX_W = 8,
    parameter int GHR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [GHR_W-1:0]  ghr,
    input logic              lk_taken,
    input logic              bp_lk,
    input logic              gp_lk,
    input logic [1:0]        vote_lk,
    input logic [1:0]        bim_u,
    input logic [1:0]        vote_u,
    input logic [BIDX_W-1:0] bidx_u,
    input logic              bp_u,
    input logic              gp_u
);
    // R1
    ghr_reset_chk: assert property (@(posedge clk) !rst_n |=> ghr == '0);

    // R5
    ghr_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ghr[0] == $past(upd_taken));

    // R5
    ghr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr));

    // R4
    agree_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_lk == gp_lk) |-> lk_taken == bp_lk);

    // R6
    pick_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_lk != gp_lk && vote_lk[1]) |-> lk_taken == gp_lk);

    // R2
    bim_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && bim_u == 2'b11)
        |=> ($past(bidx_u) != bidx_u) || bim_u == 2'b11);

    // R7
    vote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && bp_u == gp_u)
        |=> ($past(bidx_u) != bidx_u) || $stable(vote_u));

endmodule

bind tourn_predictor tourn_predictor_chk #(.BIDX_W(BIDX_W), .GHR_W(GHR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .ghr       (ghr),
    .lk_taken  (lk_taken),
    .bp_lk     (bp_lk),
    .gp_lk     (gp_lk),
    .vote_lk   (vote_lk),
    .bim_u     (bim_u),
    .vote_u    (vote_u),
    .bidx_u    (bidx_u),
    .bp_u      (bp_u),
    .gp_u      (gp_u)
);

// File: tb/tourn_predictor_bench.sv
module tourn_predictor_bench;
    localparam int PC_W    = 32;
    localparam int ALIGN_W = 2;
    localparam int BIDX_W  = 4;
    localparam int GHR_W   = 3;
    localparam int BD      = 1 << BIDX_W;
    localparam int GD      = 1 << GHR_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [1:0]       bim_m  [BD];
    logic [1:0]       glb_m  [GD];
    logic [1:0]       vote_m [BD];
    logic [GHR_W-1:0] ghr_m;

    always #4 clk = ~clk;

    tourn_predictor #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .BIDX_W(BIDX_W), .GHR_W(GHR_W))
        u_tourn_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    function automatic int bix(input logic [PC_W-1:0] pc);
        return int'(pc[ALIGN_W +: BIDX_W]);
    endfunction

    function automatic logic [1:0] step(input logic [1:0] c, input logic up);
        if (up) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    function automatic logic model_pred(input logic [PC_W-1:0] pc);
        logic b, g;
        b = bim_m[bix(pc)][1];
        g = glb_m[ghr_m][1];
        if (b == g) return b;
        return vote_m[bix(pc)][1] ? g : b;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < BD; i++) begin bim_m[i] = 2'b01; vote_m[i] = 2'b01; end
        for (int i = 0; i < GD; i++) glb_m[i] = 2'b01;
        ghr_m = '0;
    endtask

    task automatic model_update(input logic [PC_W-1:0] pc, input logic t);
        logic b, g;
        b = bim_m[bix(pc)][1];
        g = glb_m[ghr_m][1];
        if (b != g) vote_m[bix(pc)] = step(vote_m[bix(pc)], g == t);
        bim_m[bix(pc)] = step(bim_m[bix(pc)], t);
        glb_m[ghr_m]   = step(glb_m[ghr_m], t);
        ghr_m = {ghr_m[GHR_W-2:0], t};
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lk_taken=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // One cycle: drive at negedge, check lookup, then clock the update.
    task automatic cyc(input logic v, input logic [PC_W-1:0] upc, input logic t,
                       input logic [PC_W-1:0] lpc, input string req);
        @(negedge clk);
        upd_valid = v; upd_pc = upc; upd_taken = t; lk_pc = lpc;
        #1;
        check(lk_taken, model_pred(lpc), req);
        @(posedge clk);
        if (v) model_update(upc, t);
    endtask

    task automatic look(input logic [PC_W-1:0] lpc, input logic exp, input string req);
        @(negedge clk);
        upd_valid = 1'b0; lk_pc = lpc;
        #1;
        check(lk_taken, exp, req);
        check(lk_taken, model_pred(lpc), req);
    endtask

    always @(posedge clk) cycles++;

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] pool [24];
        logic [PC_W-1:0] pa, pb;
        void'($urandom(32'd1357));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state predicts not taken everywhere
        look(32'h0000_0000, 1'b0, "R1");
        look(32'h0000_003C, 1'b0, "R1");

        // R9: same-cycle lookup sees the old value, next cycle the new one
        pa = 32'h0000_0010;
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pa; upd_taken = 1'b1; lk_pc = pa;
        #1; check(lk_taken, 1'b0, "R9");
        @(posedge clk); model_update(pa, 1'b1);
        // bim=10, glb[1]=01, vote=01 -> per-address wins (R6, R3)
        look(pa, 1'b1, "R6");

        // R8: alignment bits and high bits alias onto the same entry
        look(pa | 32'h0000_0003, 1'b1, "R8");
        look(pa | 32'h8000_0000, 1'b1, "R8");
        look(pa + 32'h0000_0004, 1'b0, "R8");

        // R2/R10: saturate up on one address, then step down once
        pb = 32'h0000_0020;
        for (int i = 0; i < 6; i++) cyc(1'b1, pb, 1'b1, pb, "R2");
        cyc(1'b1, pb, 1'b0, pb, "R2");
        look(pb, model_pred(pb), "R2");
        for (int i = 0; i < 6; i++) cyc(1'b1, pb, 1'b0, pb, "R10");
        look(pb, 1'b0, "R10");

        // R5: cycles with no update leave history unchanged
        for (int i = 0; i < 4; i++) cyc(1'b0, pb, 1'b1, pa, "R5");

        // R7: alternating pattern makes components disagree and trains chooser
        for (int i = 0; i < 40; i++) cyc(1'b1, pa, i[0], pa, "R7");
        for (int i = 0; i < 40; i++) cyc(1'b1, pb, (i % 3) == 0, pb, "R6");

        // Constrained random: 24 addresses over 16 entries, biased outcomes
        for (int i = 0; i < 24; i++)
            pool[i] = {$urandom} & 32'hF000_007F;
        for (int n = 0; n < 6000; n++) begin
            int k, j;
            logic t;
            k = $urandom_range(23);
            j = $urandom_range(23);
            t = (k % 4 == 0) ? ($urandom_range(9) < 8) :
                (k % 4 == 1) ? ($urandom_range(9) < 2) :
                (k % 4 == 2) ? n[0] : $urandom_range(1);
            cyc($urandom_range(3) != 0, pool[k], t, pool[j], "R4");
        end

        // R1: reset again restores weakly-not-taken everywhere
        @(negedge clk); rst_n = 1'b0; upd_valid = 1'b0;
        @(posedge clk); model_reset();
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 24; i++) look(pool[i], 1'b0, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule